// File: doc/BRIEF.md
# Coherence Snoop Response Unit

This block decides how a cache line reacts when the cache observes another agent's bus transaction for that line. Each snoop brings a command (read, read-exclusive, upgrade, invalidate, write-invalidate), a hit flag saying whether the line is present, the line's status word, and a flag saying whether a miss for the same line is already in service. One cycle later the block returns the new status word, a pulse telling the data path to supply the line, a pulse asserting the shared signal on the bus, and an error pulse for combinations the protocol does not allow.

The protocol variant is chosen at elaboration by two parameters: whether the Owned state exists and whether the Exclusive state exists. Together these give the four classic variants: with neither, with Exclusive only, with Owned only, or with both. A third parameter enables upgrade transactions. Variants that have Owned need upgrades enabled. The block only covers the state decision. It does not move data or take part in bus arbitration.

The line state lives in status bits [2:0], coded Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4. Codes 5 to 7 are reserved. All higher status bits belong to other logic and are passed through.

Top module: `snp_resp_unit`

## Requirements
- R1: A snoop with hit_i=0 returns status_i unchanged, with supply, shared and error all low, whatever the command and busy flag.
- R2: Invalidate (cmd 3) and write-invalidate (cmd 4) set the state to Invalid from every legal state, with supply and shared low.
- R3: Read (cmd 0) to a Modified line (4) pulses supply and shared. The state moves to Owned (3) when Owned exists, and to Shared (1) otherwise.
- R4: Read-exclusive (cmd 1) to a Modified or Owned line pulses supply and sets Invalid. Read-exclusive to Shared or Exclusive sets Invalid without supply.
- R5: Read to an Owned line pulses supply and shared, and the line stays Owned. Upgrade (cmd 2) to an Owned line sets Invalid without supply.
- R6: Read to an Exclusive line pulses shared only and sets Shared. Read to a Shared line pulses shared when Exclusive exists. Without Exclusive, it leaves the word unchanged with no shared pulse.
- R7: Upgrade to a Shared line sets Invalid when upgrades are enabled. Read, read-exclusive and upgrade to an Invalid line leave the word unchanged.
- R8: A hit snoop with miss_busy_i=1 pulses error, leaves the word unchanged and pulses neither supply nor shared.
- R9: A hit snoop pulses error and leaves the word unchanged in any of these cases: the state code is reserved or absent from the variant, the command code is 5 to 7, the command is an upgrade while upgrades are disabled, or the command is an upgrade to an Exclusive or Modified line.
- R10: Status bits above the state field are always returned as received.
- R11: Outputs register on the clock edge that samples snp_vld_i=1. rsp_vld_o and the supply, shared and error pulses last exactly one cycle and stay low after a cycle without a snoop.
- R12: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_vld_i | input | 1 | Snoop present this cycle |
| snp_cmd_i | input | 3 | Snooped command code |
| hit_i | input | 1 | Line present in the cache |
| miss_busy_i | input | 1 | Miss for this line already in service |
| status_i | input | STATUS_W | Current status word of the line |
| rsp_vld_o | output | 1 | Response valid, one cycle after the snoop |
| new_status_o | output | STATUS_W | Status word to write back |
| supply_o | output | 1 | Line must supply data |
| shared_o | output | 1 | Assert shared signal on the bus |
| err_o | output | 1 | Illegal snoop or snoop during an in-service miss |

## Verification
Every result is due exactly one clock edge after the edge that samples the snoop. The bench changes its inputs on the falling edge and reads every output on the following falling edge, half a period after the capturing edge. Each vector is followed by an idle cycle. The bench checks there that the pulses have dropped, which also shows that each response belongs to its own snoop. A second instance built without Owned, Exclusive or upgrades receives the same inputs. That instance is checked against a separate table, so both the variant-dependent outcomes and the illegal-state errors are covered.

// File: rtl/snp_pkg.sv
package snp_pkg;
  localparam int ST_W = 3;

  localparam logic [ST_W-1:0] ST_I = 3'd0;
  localparam logic [ST_W-1:0] ST_S = 3'd1;
  localparam logic [ST_W-1:0] ST_E = 3'd2;
  localparam logic [ST_W-1:0] ST_O = 3'd3;
  localparam logic [ST_W-1:0] ST_M = 3'd4;

  typedef enum logic [2:0] {
    C_RD   = 3'd0,
    C_RDX  = 3'd1,
    C_UPG  = 3'd2,
    C_INV  = 3'd3,
    C_WINV = 3'd4
  } cmd_e;

  typedef struct packed {
    logic [ST_W-1:0] nxt_st;
    logic            keep;    // null transition: word unchanged
    logic            supply;
    logic            shared;
    logic            bad;
  } xlate_t;
endpackage

// File: rtl/snp_xlate.sv
module snp_xlate
  import snp_pkg::*;
#(
  parameter bit HAS_OWNED = 1'b1,
  parameter bit HAS_EXCL  = 1'b1,
  parameter bit DO_UPGR   = 1'b1
) (
  input  logic [2:0]      cmd_i,
  input  logic [ST_W-1:0] st_i,
  output xlate_t          res_o
);
  logic st_ok;

  always_comb begin
    st_ok = (st_i == ST_I) || (st_i == ST_S) || (st_i == ST_M) ||
            (HAS_EXCL && (st_i == ST_E)) || (HAS_OWNED && (st_i == ST_O));
    res_o.nxt_st = st_i;
    res_o.keep   = 1'b1;
    res_o.supply = 1'b0;
    res_o.shared = 1'b0;
    res_o.bad    = 1'b0;
    if (!st_ok) begin
      res_o.bad = 1'b1;
    end else begin
      unique case (cmd_i)
        C_INV, C_WINV: begin
          res_o.keep   = 1'b0;
          res_o.nxt_st = ST_I;
        end
        C_RD: begin
          unique case (st_i)
            ST_S: if (HAS_EXCL) begin
              res_o.keep   = 1'b0;
              res_o.shared = 1'b1;
            end
            ST_E: begin
              res_o.keep   = 1'b0;
              res_o.nxt_st = ST_S;
              res_o.shared = 1'b1;
            end
            ST_O: begin
              res_o.keep   = 1'b0;
              res_o.supply = 1'b1;
              res_o.shared = 1'b1;
            end
            ST_M: begin
              res_o.keep   = 1'b0;
              res_o.nxt_st = HAS_OWNED ? ST_O : ST_S;
              res_o.supply = 1'b1;
              res_o.shared = 1'b1;
            end
            default: ;
          endcase
        end
        C_RDX: begin
          if (st_i != ST_I) begin
            res_o.keep   = 1'b0;
            res_o.nxt_st = ST_I;
            res_o.supply = (st_i == ST_O) || (st_i == ST_M);
          end
        end
        C_UPG: begin
          if (!DO_UPGR) begin
            res_o.bad = 1'b1;
          end else begin
            unique case (st_i)
              ST_S, ST_O: begin
                res_o.keep   = 1'b0;
                res_o.nxt_st = ST_I;
              end
              ST_E, ST_M: res_o.bad = 1'b1;
              default: ;
            endcase
          end
        end
        default: res_o.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/snp_rsp_reg.sv
module snp_rsp_reg #(
  parameter int STATUS_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                supply_i,
  input  logic                shared_i,
  input  logic                err_i,
  output logic                vld_o,
  output logic [STATUS_W-1:0] status_o,
  output logic                supply_o,
  output logic                shared_o,
  output logic                err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      status_o <= '0;
      supply_o <= 1'b0;
      shared_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vld_o    <= vld_i;
      supply_o <= vld_i & supply_i;
      shared_o <= vld_i & shared_i;
      err_o    <= vld_i & err_i;
      if (vld_i) status_o <= status_i;
    end
  end

  AST_PULSE_HAS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_o || shared_o || err_o) |-> vld_o); // R11
endmodule

// File: rtl/snp_resp_unit.sv
module snp_resp_unit
  import snp_pkg::*;
#(
  parameter int STATUS_W  = 8,
  parameter bit HAS_OWNED = 1'b1,
  parameter bit HAS_EXCL  = 1'b1,
  parameter bit DO_UPGR   = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                snp_vld_i,
  input  logic [2:0]          snp_cmd_i,
  input  logic                hit_i,
  input  logic                miss_busy_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic                rsp_vld_o,
  output logic [STATUS_W-1:0] new_status_o,
  output logic                supply_o,
  output logic                shared_o,
  output logic                err_o
);
  localparam int HI_W = STATUS_W - ST_W;

  xlate_t              xl;
  logic                err_d, act_d;
  logic [STATUS_W-1:0] status_d;

  snp_xlate #(
    .HAS_OWNED(HAS_OWNED),
    .HAS_EXCL (HAS_EXCL),
    .DO_UPGR  (DO_UPGR)
  ) u_xlate (
    .cmd_i(snp_cmd_i),
    .st_i (status_i[ST_W-1:0]),
    .res_o(xl)
  );

  always_comb begin
    err_d    = hit_i & (miss_busy_i | xl.bad);
    act_d    = hit_i & ~err_d;
    status_d = status_i;
    if (act_d && !xl.keep) status_d = {status_i[STATUS_W-1:ST_W], xl.nxt_st};
  end

  snp_rsp_reg #(.STATUS_W(STATUS_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (snp_vld_i),
    .status_i(status_d),
    .supply_i(act_d & xl.supply),
    .shared_i(act_d & xl.shared),
    .err_i   (err_d),
    .vld_o   (rsp_vld_o),
    .status_o(new_status_o),
    .supply_o(supply_o),
    .shared_o(shared_o),
    .err_o   (err_o)
  );

  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && !hit_i) |=> (rsp_vld_o && !supply_o && !shared_o && !err_o &&
                               new_status_o == $past(status_i))); // R1

  AST_INV_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && hit_i && !miss_busy_i && !xl.bad &&
     (snp_cmd_i == C_INV || snp_cmd_i == C_WINV))
    |=> (new_status_o[ST_W-1:0] == ST_I && !supply_o && !shared_o)); // R2

  AST_DIRTY_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && hit_i && !miss_busy_i && !xl.bad &&
     (status_i[ST_W-1:0] == ST_M || status_i[ST_W-1:0] == ST_O) &&
     (snp_cmd_i == C_RD || snp_cmd_i == C_RDX)) |=> supply_o); // R4

  AST_BUSY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && hit_i && miss_busy_i) |=> (err_o && !supply_o && !shared_o &&
                                             new_status_o == $past(status_i))); // R8

  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_vld_i |=> (new_status_o[STATUS_W-1:ST_W] ==
                   $past(status_i[STATUS_W-1:ST_W]))); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_vld_i |=> (!rsp_vld_o && !supply_o && !shared_o && !err_o)); // R11

  initial begin
    AST_HI_WIDTH: assert (HI_W >= 1); // R10
  end
endmodule

// File: tb/snp_resp_unit_tb_top.sv
module snp_resp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic snp_vld = 1'b0;
  logic [2:0] cmd = '0;
  logic hit = 1'b0;
  logic busy = 1'b0;
  logic [SW-1:0] status = '0;

  logic a_vld, a_sup, a_shr, a_err;
  logic [SW-1:0] a_st;
  logic b_vld, b_sup, b_shr, b_err;
  logic [SW-1:0] b_st;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snp_resp_unit #(.STATUS_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .snp_vld_i(snp_vld), .snp_cmd_i(cmd),
    .hit_i(hit), .miss_busy_i(busy), .status_i(status),
    .rsp_vld_o(a_vld), .new_status_o(a_st), .supply_o(a_sup),
    .shared_o(a_shr), .err_o(a_err));

  snp_resp_unit #(.STATUS_W(SW), .HAS_OWNED(1'b0), .HAS_EXCL(1'b0),
                  .DO_UPGR(1'b0)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_ni), .snp_vld_i(snp_vld), .snp_cmd_i(cmd),
    .hit_i(hit), .miss_busy_i(busy), .status_i(status),
    .rsp_vld_o(b_vld), .new_status_o(b_st), .supply_o(b_sup),
    .shared_o(b_shr), .err_o(b_err));

  // {hit, busy, cmd[2:0], state[2:0], exp_state[2:0], sup, shr, err}
  localparam int NA = 25;
  localparam logic [13:0] VEC_A [NA] = '{
    {1'b1,1'b0,3'd0,3'd4,3'd3,1'b1,1'b1,1'b0}, // R3 read M->O
    {1'b1,1'b0,3'd0,3'd3,3'd3,1'b1,1'b1,1'b0}, // R5 read O
    {1'b1,1'b0,3'd0,3'd2,3'd1,1'b0,1'b1,1'b0}, // R6 read E->S
    {1'b1,1'b0,3'd0,3'd1,3'd1,1'b0,1'b1,1'b0}, // R6 read S
    {1'b1,1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b0}, // R7 read I
    {1'b1,1'b0,3'd1,3'd4,3'd0,1'b1,1'b0,1'b0}, // R4 rdx M
    {1'b1,1'b0,3'd1,3'd3,3'd0,1'b1,1'b0,1'b0}, // R4 rdx O
    {1'b1,1'b0,3'd1,3'd2,3'd0,1'b0,1'b0,1'b0}, // R4 rdx E
    {1'b1,1'b0,3'd1,3'd1,3'd0,1'b0,1'b0,1'b0}, // R4 rdx S
    {1'b1,1'b0,3'd1,3'd0,3'd0,1'b0,1'b0,1'b0}, // R7 rdx I
    {1'b1,1'b0,3'd2,3'd1,3'd0,1'b0,1'b0,1'b0}, // R7 upg S
    {1'b1,1'b0,3'd2,3'd3,3'd0,1'b0,1'b0,1'b0}, // R5 upg O
    {1'b1,1'b0,3'd2,3'd0,3'd0,1'b0,1'b0,1'b0}, // R7 upg I
    {1'b1,1'b0,3'd2,3'd2,3'd2,1'b0,1'b0,1'b1}, // R9 upg E
    {1'b1,1'b0,3'd2,3'd4,3'd4,1'b0,1'b0,1'b1}, // R9 upg M
    {1'b1,1'b0,3'd3,3'd4,3'd0,1'b0,1'b0,1'b0}, // R2 inv M
    {1'b1,1'b0,3'd3,3'd2,3'd0,1'b0,1'b0,1'b0}, // R2 inv E
    {1'b1,1'b0,3'd3,3'd0,3'd0,1'b0,1'b0,1'b0}, // R2 inv I
    {1'b1,1'b0,3'd4,3'd3,3'd0,1'b0,1'b0,1'b0}, // R2 winv O
    {1'b1,1'b0,3'd4,3'd1,3'd0,1'b0,1'b0,1'b0}, // R2 winv S
    {1'b1,1'b0,3'd5,3'd1,3'd1,1'b0,1'b0,1'b1}, // R9 bad cmd
    {1'b1,1'b0,3'd0,3'd6,3'd6,1'b0,1'b0,1'b1}, // R9 bad state
    {1'b0,1'b0,3'd0,3'd4,3'd4,1'b0,1'b0,1'b0}, // R1 miss
    {1'b0,1'b1,3'd1,3'd3,3'd3,1'b0,1'b0,1'b0}, // R1 miss busy
    {1'b1,1'b1,3'd0,3'd4,3'd4,1'b0,1'b0,1'b1}  // R8 busy
  };

  // variant without Owned, Exclusive or upgrades
  localparam int NB = 7;
  localparam logic [13:0] VEC_B [NB] = '{
    {1'b1,1'b0,3'd0,3'd4,3'd1,1'b1,1'b1,1'b0}, // R3 read M->S
    {1'b1,1'b0,3'd0,3'd1,3'd1,1'b0,1'b0,1'b0}, // R6 read S null
    {1'b1,1'b0,3'd2,3'd1,3'd1,1'b0,1'b0,1'b1}, // R9 upg disabled
    {1'b1,1'b0,3'd0,3'd2,3'd2,1'b0,1'b0,1'b1}, // R9 E absent
    {1'b1,1'b0,3'd0,3'd3,3'd3,1'b0,1'b0,1'b1}, // R9 O absent
    {1'b1,1'b0,3'd3,3'd4,3'd0,1'b0,1'b0,1'b0}, // R2 inv M
    {1'b1,1'b0,3'd1,3'd4,3'd0,1'b1,1'b0,1'b0}  // R4 rdx M
  };

  task automatic chk(input string req, input logic [SW+3:0] act,
                     input logic [SW+3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [13:0] v, input int idx, input bit use_b,
                         input string req);
    logic [SW-1:0] st_in, st_exp;
    logic [SW+3:0] got;
    st_in  = {5'(idx * 7 + 3), v[8:6]};
    st_exp = {st_in[SW-1:3], v[5:3]};
    @(negedge clk);
    snp_vld = 1'b1; hit = v[13]; busy = v[12]; cmd = v[11:9]; status = st_in;
    @(negedge clk);
    snp_vld = 1'b0;
    got = use_b ? {b_vld, b_st, b_sup, b_shr, b_err} : {a_vld, a_st, a_sup, a_shr, a_err};
    chk(req, got, {1'b1, st_exp, v[2:0]});
    @(negedge clk);
    got = use_b ? {b_vld, b_st, b_sup, b_shr, b_err} : {a_vld, a_st, a_sup, a_shr, a_err};
    chk("R11 idle", {got[SW+3], 8'h0, got[2:0]}, '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    snp_vld = 1'b1; hit = 1'b1; cmd = 3'd0; status = 8'hF4;
    // R12 reset holds outputs low even with a snoop present
    chk("R12 reset a", {a_vld, a_st, a_sup, a_shr, a_err}, '0);
    chk("R12 reset b", {b_vld, b_st, b_sup, b_shr, b_err}, '0);
    @(negedge clk);
    snp_vld = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 no snoop", {a_vld, a_st, a_sup, a_shr, a_err}, '0);

    for (int i = 0; i < NA; i++) run_vec(VEC_A[i], i, 1'b0, "R1-R10 table a");
    for (int i = 0; i < NB; i++) run_vec(VEC_B[i], i + 40, 1'b1, "R3/R6/R9 table b");

    // R11 back-to-back snoops: each response lands one edge later
    @(negedge clk);
    snp_vld = 1'b1; hit = 1'b1; busy = 1'b0; cmd = 3'd0; status = 8'hA4;
    @(negedge clk);
    chk("R11 b2b first", {a_vld, a_st, a_sup, a_shr, a_err}, {1'b1, 8'hA3, 3'b110});
    cmd = 3'd3; status = 8'h52;
    @(negedge clk);
    snp_vld = 1'b0;
    chk("R11 b2b second", {a_vld, a_st, a_sup, a_shr, a_err}, {1'b1, 8'h50, 3'b000});
    @(negedge clk);
    chk("R11 b2b drop", {a_vld, 8'h0, a_sup, a_shr, a_err}, '0);
    // R10 upper bits kept on a state change with all-ones upper field
    @(negedge clk);
    snp_vld = 1'b1; cmd = 3'd1; status = 8'hFB;
    @(negedge clk);
    snp_vld = 1'b0;
    chk("R10 upper kept", {a_vld, a_st, a_sup, a_shr, a_err}, {1'b1, 8'hF8, 3'b100});
    summary();
  end
endmodule